// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

This block is a word-addressed memory in which every 32-bit data word carries one presence flag, so that each stored item is 33 bits wide in effect. The flag marks the word as full (holding a value that has not yet been consumed) or empty. Producer and consumer threads use the flag to hand values to one another one word at a time, without a separate lock. Flags live in a per-line tag store: four consecutive words form a line, and that line's tag entry holds the four flags.

A single request port takes an opcode, a word address and write data. Synchronizing opcodes test the flag of the addressed word and change it in the same cycle as the data access, so the test and the update cannot be split. When the flag is in the wrong state for the operation, the memory raises a trap flag on the response and changes nothing. The trap handler itself lives outside this block. Every request gets a registered response one cycle later. That response carries the word as it stood before the request, the flag before the request, and the trap flag.

Top module: `fe_sync_mem`

## Requirements
- R1: While reset is held and in the first cycle after it, rsp_valid is 0. Reset marks every word empty (flag 0). Data contents after reset are undefined.
- R2: A request accepted at a clock edge (req_valid 1) produces rsp_valid 1 after that same edge, and an idle cycle produces rsp_valid 0. rsp_rdata and rsp_fe_old give the word and its flag as they were before the request.
- R3: Opcode 1 (plain read) never traps and leaves both the flag and the data unchanged.
- R4: Opcode 2 (plain write) never traps. It writes req_wdata and keeps the flag as it was.
- R5: Opcode 3 (read, trap if empty) traps when the flag is 0. When the flag is 1 it returns the word and the flag stays 1.
- R6: Opcode 4 (read and take) traps when the flag is 0. When the flag is 1 it returns the word and clears the flag to 0.
- R7: Opcode 5 (write and fill) never traps. It writes req_wdata and sets the flag to 1.
- R8: Opcode 6 (write and fill, trap if full) traps when the flag is 1. When the flag is 0 it writes req_wdata and sets the flag to 1.
- R9: A request that traps changes neither the data word nor its flag.
- R10: A request at the same address in the very next cycle sees the data and flag left by the previous request.
- R11: Opcodes 0 and 7 are no-ops. They respond without a trap and change nothing.
- R12: Address bits [1:0] select the word within a line. Changing one word's flag leaves the flags of the other words, including those in the same line, untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0..7) |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Write data for the store opcodes |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Word content before the request |
| rsp_fe_old | output | 1 | Flag before the request (1 = full) |
| rsp_trap | output | 1 | Operation refused; nothing was changed |

## Verification
A flag test and a write to the same word fall in the same cycle. A trap must also suppress that write in the very cycle where the test fails. The bench issues, one request per cycle at a single address, a sequence of synchronizing operations that trap and then succeed in turn. Each response is judged against a bench model of the word and its flag, and the next request is read back immediately to confirm that a trapped write left no trace.

// File: rtl/fe_sync_pkg.sv
// Package: opcode encoding shared by the synchronizing memory and its bench.
// Assumes a 3-bit opcode field; unlisted values are treated as no-ops.
package fe_sync_pkg;

    typedef enum logic [2:0] {
        FE_NOP  = 3'd0,
        FE_LD   = 3'd1,
        FE_ST   = 3'd2,
        FE_LDT  = 3'd3,
        FE_LDE  = 3'd4,
        FE_STF  = 3'd5,
        FE_STFT = 3'd6,
        FE_RSV  = 3'd7
    } fe_op_e;

endpackage

// File: rtl/fe_data_array.sv
// Module: plain data storage, one word per address, no reset.
// Assumes a single write port; the read is asynchronous so the top can
// register the pre-write word together with the tag result.
module fe_data_array #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write the addressed word when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Present the addressed word before any write this cycle.
    assign rdata = mem[addr];

endmodule

// File: rtl/fe_tag_store.sv
// Module: per-line tag entries, each holding the flags of its words.
// Assumes DEPTH is a multiple of WPL and WPL is a power of two; the low
// address bits pick the word inside the line.
module fe_tag_store #(
    parameter int DEPTH = 256,
    parameter int WPL   = 4,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int OFF_W  = $clog2(WPL),
    localparam int LINES  = DEPTH / WPL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              flag_new,
    output logic              flag_old
);

    localparam int LINE_W = ADDR_W - OFF_W;

    logic [LINE_W-1:0] line_idx;
    logic [OFF_W-1:0]  word_idx;
    logic [DEPTH-1:0]  flags_flat;

    assign line_idx = addr[ADDR_W-1:OFF_W];
    assign word_idx = addr[OFF_W-1:0];

    for (genvar ln = 0; ln < LINES; ln++) begin : g_line
        logic [WPL-1:0] entry;

        // Clear on reset; otherwise update one flag of this line on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry <= '0;
            end else if (we && (line_idx == LINE_W'(ln))) begin
                entry[word_idx] <= flag_new;
            end
        end

        assign flags_flat[ln*WPL +: WPL] = entry;
    end

    // Pick the addressed flag out of the flattened tag image.
    assign flag_old = flags_flat[addr];

    // No flag moves unless the top asked for a flag write.
    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(flags_flat));

endmodule

// File: rtl/fe_op_decode.sv
// Module: combinational rule table for the synchronizing opcodes.
// Assumes the flag input is the addressed word's current flag; outputs
// are not gated by request valid (the top does that).
module fe_op_decode
    import fe_sync_pkg::*;
(
    input  fe_op_e op,
    input  logic   flag_old,
    output logic   trap,
    output logic   data_we,
    output logic   flag_we,
    output logic   flag_new
);

    // Decide trap, data write and flag update from opcode and flag.
    always_comb begin
        trap     = 1'b0;
        data_we  = 1'b0;
        flag_we  = 1'b0;
        flag_new = flag_old;
        unique case (op)
            FE_ST: begin
                data_we = 1'b1;
            end
            FE_LDT: begin
                trap = !flag_old;
            end
            FE_LDE: begin
                trap = !flag_old;
                if (flag_old) begin
                    flag_we  = 1'b1;
                    flag_new = 1'b0;
                end
            end
            FE_STF: begin
                data_we  = 1'b1;
                flag_we  = 1'b1;
                flag_new = 1'b1;
            end
            FE_STFT: begin
                trap = flag_old;
                if (!flag_old) begin
                    data_we  = 1'b1;
                    flag_we  = 1'b1;
                    flag_new = 1'b1;
                end
            end
            default: begin
                trap = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fe_sync_mem.sv
// Module: top of the full/empty tagged memory. One request per cycle,
// registered response the next cycle. Assumes callers treat a trap as
// "nothing happened" and re-issue after their handler runs.
module fe_sync_mem
    import fe_sync_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    parameter int WPL    = 4,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_fe_old,
    output logic              rsp_trap
);

    fe_op_e            op_c;
    logic              flag_old;
    logic              dec_trap;
    logic              dec_data_we;
    logic              dec_flag_we;
    logic              dec_flag_new;
    logic [DATA_W-1:0] word_old;
    fe_op_e            rsp_op_q;

    assign op_c = fe_op_e'(req_op);

    fe_op_decode u_dec (
        .op       (op_c),
        .flag_old (flag_old),
        .trap     (dec_trap),
        .data_we  (dec_data_we),
        .flag_we  (dec_flag_we),
        .flag_new (dec_flag_new)
    );

    fe_data_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
        .clk   (clk),
        .we    (req_valid && dec_data_we),
        .addr  (req_addr),
        .wdata (req_wdata),
        .rdata (word_old)
    );

    fe_tag_store #(.DEPTH(DEPTH), .WPL(WPL)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (req_valid && dec_flag_we),
        .addr     (req_addr),
        .flag_new (dec_flag_new),
        .flag_old (flag_old)
    );

    // Register the response: valid strobe with reset, payload without.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_trap  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_trap  <= req_valid && dec_trap;
        end
        rsp_rdata  <= word_old;
        rsp_fe_old <= flag_old;
        rsp_op_q   <= op_c;
    end

    // Each accepted request answers one cycle later.
    assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // Idle cycles give no response.
    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // Plain accesses and no-ops never trap.
    assert_plain_no_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_op_q == FE_LD || rsp_op_q == FE_ST ||
                       rsp_op_q == FE_NOP || rsp_op_q == FE_RSV)) |-> !rsp_trap);

    // A trap means the flag was full for the fill-trap store, empty otherwise.
    assert_trap_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap) |-> (rsp_fe_old == (rsp_op_q == FE_STFT)));

endmodule

// File: tb/sim_fe_sync_mem.sv
// Bench: sweeps every address through a fixed operation sequence and
// compares each response against a model kept in the bench.
module sim_fe_sync_mem;
    import fe_sync_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [7:0]  req_addr = 8'd0;
    logic [31:0] req_wdata = 32'd0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_fe_old;
    logic        rsp_trap;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_data  [256];
    logic        m_flag  [256];
    logic        m_known [256];

    always #2.5 clk = ~clk;

    fe_sync_mem u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_fe_old(rsp_fe_old),
        .rsp_trap  (rsp_trap)
    );

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Issue one request at the falling edge and judge it one cycle later.
    task automatic do_op(input logic [2:0] op, input int a, input logic [31:0] wd,
                         input string extra);
        logic exp_trap;
        logic exp_flag;
        logic [31:0] exp_data;
        logic known;
        string req;
        exp_flag = m_flag[a];
        exp_data = m_data[a];
        known    = m_known[a];
        case (op)
            3'd3, 3'd4: exp_trap = !m_flag[a];
            3'd6:       exp_trap = m_flag[a];
            default:    exp_trap = 1'b0;
        endcase
        req = exp_trap ? {tag_of(op), "/R9"} : tag_of(op);
        if (extra != "") req = {req, "/", extra};
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = 8'(a);
        req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        check("R2", "rsp_valid", 32'(rsp_valid), 32'd1);
        check(req, "rsp_trap", 32'(rsp_trap), 32'(exp_trap));
        check(req, "rsp_fe_old", 32'(rsp_fe_old), 32'(exp_flag));
        if (known) check(req, "rsp_rdata", rsp_rdata, exp_data);
        if (!exp_trap) begin
            case (op)
                3'd2: begin m_data[a] = wd; m_known[a] = 1'b1; end
                3'd4: m_flag[a] = 1'b0;
                3'd5, 3'd6: begin m_data[a] = wd; m_known[a] = 1'b1; m_flag[a] = 1'b1; end
                default: ;
            endcase
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_data[i] = '0; m_flag[i] = 1'b0; m_known[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R2", "idle rsp_valid", 32'(rsp_valid), 32'd0);

        // Per-address sequence, one request per cycle (R10 back-to-back).
        for (int a = 0; a < 256; a++) begin
            logic [31:0] base;
            base = 32'h5A00_0000 ^ (32'(a) * 32'h0001_0203);
            do_op(3'd2, a, base ^ 32'h1111_1111, "R12");
            do_op(3'd3, a, 32'hDEAD_0001, "R10");
            do_op(3'd4, a, 32'hDEAD_0002, "R10");
            do_op(3'd1, a, 32'hDEAD_0003, "R9");
            do_op(3'd6, a, base ^ 32'h2222_2222, "R10");
            do_op(3'd6, a, base ^ 32'h3333_3333, "R9");
            do_op(3'd3, a, 32'hDEAD_0004, "R10");
            do_op(3'd5, a, base ^ 32'h4444_4444, "R10");
            do_op(3'd4, a, 32'hDEAD_0005, "R10");
            do_op((a % 2 == 0) ? 3'd0 : 3'd7, a, 32'hDEAD_0006, "R11");
            do_op(3'd2, a, base ^ 32'h5555_5555, "R4");
            do_op(3'd5, a, base ^ 32'h6666_6666, "R7");
        end

        // Final pass: every word full with its last value, neighbours intact (R12).
        for (int a = 0; a < 256; a++) begin
            do_op(3'd1, a, 32'h0, "R12");
        end

        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R2", "rsp_valid after idle", 32'(rsp_valid), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule